// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, based on its 48-bit destination address. The MAC raises a start strobe at the beginning of each frame and then presents the six destination address bytes, one per cycle, on a byte port qualified by a valid flag. As the bytes arrive, the block updates a bit-serial CRC-32 of the address and assembles the address in a register.

One cycle after the sixth byte, the block raises a decision strobe together with an accept flag. Both hold until the next start strobe.

The rules for acceptance are as follows:
- An individual address is accepted only when it exactly matches the programmed station address.
- The all-ones broadcast address is always accepted.
- Any other group address is looked up in a 64-bit hash filter. The index is the top six bits of the address CRC.
- An all-multicast input opens the whole hash filter.
- A promiscuous bit in the mode word accepts every frame.

Top module: `dest_addr_filter`

## Requirements
- R1: A byte is taken on a clock edge where `byteValid` is high. The first byte taken after a start strobe is address byte 0, and it is compared with `stationAddr[7:0]`. Byte k is compared with `stationAddr[8k+7:8k]`. Bit 0 of byte 0 is the group bit.
- R2: After reset, `decisionValid` and `acceptOut` are 0. `decisionValid` stays 0 until the sixth byte is taken and is 1 in the cycle after it. Once high, it holds, with `acceptOut` unchanged, until a start strobe. A start strobe drives `decisionValid` to 0 in the following cycle.
- R3: Bytes that arrive after the sixth byte, or after reset but before any start strobe, have no effect on the outputs.
- R4: When a start strobe and `byteValid` are high in the same cycle, that byte is taken as address byte 0.
- R5: An address with group bit 0 is accepted exactly when it equals `stationAddr`. The hash filter is not consulted for it.
- R6: The address 48'hFFFF_FFFF_FFFF is always accepted, even with an all-zero hash filter.
- R7: The hash index of a group address is computed as follows:
  - The CRC starts at 32'hFFFF_FFFF.
  - It is shifted right once per address bit, and the reflected polynomial 32'hEDB88320 is XORed in when the input bit XOR the CRC's bit 0 is 1.
  - The bits are taken bytes in order, least significant bit first.
  - The index is CRC[31:26]. Index bits [5:4] select 16-bit word w = `hashFilter[16w+15:16w]`, and bits [3:0] select the bit within that word.
  - The address is accepted when that filter bit is 1.
- R8: With `allMultiEn` high, every group address is accepted regardless of `hashFilter`. Individual addresses are unaffected.
- R9: `modeWord[15]` high accepts every address. The other bits of `modeWord` have no effect.
- R10: A `stationAddr` whose bit 0 is 1 never produces an exact match. An address equal to it is judged only by the hash rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Start of a new destination address |
| byteValid | input | 1 | `byteIn` carries an address byte |
| byteIn | input | 8 | Address byte, byte 0 first |
| stationAddr | input | 48 | Station address, byte 0 in bits [7:0] |
| hashFilter | input | 64 | Multicast hash filter, four 16-bit words |
| modeWord | input | 16 | Mode word; bit 15 selects promiscuous |
| allMultiEn | input | 1 | Accept all group addresses |
| acceptOut | output | 1 | Frame accepted; meaningful while `decisionValid` |
| decisionValid | output | 1 | Decision available and held |

## Verification
A start strobe can fall in the same cycle as an address byte. In that cycle, clearing the previous decision and capturing the new byte 0 both happen. The bench sends an address with its first byte merged into the start cycle and expects exactly the same verdict as the plain two-step sequence. It also checks that a held decision drops in the cycle after such a start. The bench further checks that a start arriving while a decision is held does not leave stale CRC or address bytes in the next result, by running an accepted address followed directly by a rejected one.

// File: rtl/addr_filter_pkg.sv
`timescale 1ns/1ps
package addr_filter_pkg;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic clr;     // restart address capture and CRC
    logic load;    // take byteIn this cycle
    logic finish;  // this byte is the last one: register the verdict
  } ctrl_t;
endpackage

// File: rtl/addr_filter_ctrl.sv
`timescale 1ns/1ps
module addr_filter_ctrl
  import addr_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = $clog2(ADDR_BYTES),
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic             byteValid,
  output ctrl_t            ctrl,
  output logic [IDX_W-1:0] byteIdx,
  output logic             decisionValid
);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             validReg;
  logic             take;

  // A start with a byte in the same cycle makes that byte number 0.
  assign take    = byteValid && (startStrobe || (byteCnt < DONE));
  assign byteIdx = startStrobe ? '0 : IDX_W'(byteCnt);

  always_comb begin
    ctrl.clr    = startStrobe;
    ctrl.load   = take;
    ctrl.finish = take && (byteIdx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= DONE;   // ignore bytes until the first start
      validReg <= 1'b0;
    end else begin
      if (startStrobe)   byteCnt <= take ? CNT_W'(1) : '0;
      else if (take)     byteCnt <= byteCnt + CNT_W'(1);

      if (ctrl.finish)      validReg <= 1'b1;
      else if (startStrobe) validReg <= 1'b0;
    end
  end

  assign decisionValid = validReg;
endmodule

// File: rtl/addr_filter_dp.sv
`timescale 1ns/1ps
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int IDX_W    = $clog2(ADDR_BYTES),
  localparam int ADDR_W   = 8 * ADDR_BYTES,
  localparam int FILTER_W = 1 << HASH_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [IDX_W-1:0]    byteIdx,
  input  logic [7:0]          byteIn,
  input  logic [ADDR_W-1:0]   stationAddr,
  input  logic [FILTER_W-1:0] hashFilter,
  input  logic                promiscEn,
  input  logic                allMultiEn,
  output logic                acceptOut
);
  logic [31:0]          crcReg, crcBase, crcNext;
  logic [ADDR_W-1:0]    addrReg, addrBase, addrNext;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 isGroup, isBcast, stationHit, hashHit, verdict;
  logic                 acceptReg;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    crcBase  = ctrl.clr ? CRC_SEED : crcReg;
    addrBase = ctrl.clr ? '0 : addrReg;
    crcNext  = ctrl.load ? crcByte(crcBase, byteIn) : crcBase;
    addrNext = addrBase;
    if (ctrl.load) addrNext[8*byteIdx +: 8] = byteIn;
  end

  assign hashIdx    = crcNext[31 -: HASH_BITS];
  assign isGroup    = addrNext[0];
  assign isBcast    = &addrNext;
  assign stationHit = !isGroup && (addrNext == stationAddr);
  assign hashHit    = isGroup && (allMultiEn || hashFilter[hashIdx]);
  assign verdict    = promiscEn || isBcast || stationHit || hashHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= CRC_SEED;
      addrReg   <= '0;
      acceptReg <= 1'b0;
    end else begin
      if (ctrl.clr || ctrl.load) begin
        crcReg  <= crcNext;
        addrReg <= addrNext;
      end
      if (ctrl.finish)   acceptReg <= verdict;
      else if (ctrl.clr) acceptReg <= 1'b0;
    end
  end

  assign acceptOut = acceptReg;
endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int ADDR_BYTES  = 6,
  parameter int HASH_BITS   = 6,
  parameter int PROMISC_BIT = 15,
  localparam int IDX_W    = $clog2(ADDR_BYTES),
  localparam int ADDR_W   = 8 * ADDR_BYTES,
  localparam int FILTER_W = 1 << HASH_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startStrobe,
  input  logic                byteValid,
  input  logic [7:0]          byteIn,
  input  logic [ADDR_W-1:0]   stationAddr,
  input  logic [FILTER_W-1:0] hashFilter,
  input  logic [15:0]         modeWord,
  input  logic                allMultiEn,
  output logic                acceptOut,
  output logic                decisionValid
);
  ctrl_t            ctrl;
  logic [IDX_W-1:0] byteIdx;
  logic             unusedModeBits;

  assign unusedModeBits = ^(modeWord & ~(16'd1 << PROMISC_BIT));

  addr_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .byteValid(byteValid),
    .ctrl(ctrl), .byteIdx(byteIdx), .decisionValid(decisionValid)
  );

  addr_filter_dp #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteIdx(byteIdx), .byteIn(byteIn),
    .stationAddr(stationAddr), .hashFilter(hashFilter),
    .promiscEn(modeWord[PROMISC_BIT]), .allMultiEn(allMultiEn),
    .acceptOut(acceptOut)
  );
endmodule

// File: rtl/dest_addr_filter_chk.sv
`timescale 1ns/1ps
module dest_addr_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startStrobe,
  input logic        byteValid,
  input logic [15:0] modeWord,
  input logic        acceptOut,
  input logic        decisionValid
);
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !startStrobe |=> decisionValid);                         // R2
  AST_VERDICT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !startStrobe |=> $stable(acceptOut));                    // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> !decisionValid);                                          // R2
  AST_RISE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decisionValid) |-> $past(byteValid));                               // R1
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decisionValid) && $past(modeWord[15]) |-> acceptOut);               // R9
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .byteValid(byteValid),
  .modeWord(modeWord), .acceptOut(acceptOut), .decisionValid(decisionValid)
);

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
module dest_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic [47:0] stationAddr = 48'h0;
  logic [63:0] hashFilter = 64'h0;
  logic [15:0] modeWord = 16'h0;
  logic        allMultiEn = 1'b0;
  logic        acceptOut, decisionValid;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dest_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .byteValid(byteValid),
    .byteIn(byteIn), .stationAddr(stationAddr), .hashFilter(hashFilter),
    .modeWord(modeWord), .allMultiEn(allMultiEn),
    .acceptOut(acceptOut), .decisionValid(decisionValid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hash index per R7, from the specification.
  function automatic logic [5:0] hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (c[0] ^ a[k]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    return c[31:26];
  endfunction

  // Sends one address; on return (a falling edge) the decision is visible.
  task automatic sendAddr(input logic [47:0] a, input bit merged);
    @(negedge clk);
    startStrobe = 1'b1;
    byteValid   = merged;
    byteIn      = a[7:0];
    @(negedge clk);
    startStrobe = 1'b0;
    for (int i = (merged ? 1 : 0); i < 6; i++) begin
      byteValid = 1'b1;
      byteIn    = a[8*i +: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic expectVerdict(input string req, input logic [47:0] a, input bit exp);
    sendAddr(a, 1'b0);
    check({req, " valid"}, decisionValid, 1'b1);
    check({req, " accept"}, acceptOut, exp);
  endtask

  task automatic testReset();
    check("R2 reset valid", decisionValid, 1'b0);
    check("R2 reset accept", acceptOut, 1'b0);
    // R3: bytes before any start are ignored
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      byteValid = 1'b1; byteIn = 8'hFF; @(negedge clk);
    end
    byteValid = 1'b0;
    check("R3 bytes before start", decisionValid, 1'b0);
  endtask

  task automatic testStation();
    stationAddr = 48'h5544_3322_1100;
    hashFilter  = '1;
    expectVerdict("R5 R1 station match", 48'h5544_3322_1100, 1'b1);
    expectVerdict("R5 unicast mismatch", 48'h5544_3322_1102, 1'b0);
    expectVerdict("R1 byte order swapped", 48'h0011_2233_4455 & 48'hFFFF_FFFF_FFFE, 1'b0);
    hashFilter = '0;
  endtask

  task automatic testBroadcast();
    hashFilter = '0;
    expectVerdict("R6 broadcast", 48'hFFFF_FFFF_FFFF, 1'b1);
  endtask

  task automatic testHash();
    logic [47:0] g = 48'h0000_5E00_0001;
    logic [5:0]  h = hashOf(g);
    hashFilter = 64'd1 << h;
    expectVerdict("R7 hash bit set", g, 1'b1);
    hashFilter = ~(64'd1 << h);
    expectVerdict("R7 hash bit clear", g, 1'b0);
    allMultiEn = 1'b1; hashFilter = '0;
    expectVerdict("R8 all-multicast group", g, 1'b1);
    stationAddr = 48'h0000_0000_0A02;
    expectVerdict("R8 all-multicast unicast", 48'h0000_0000_0B02, 1'b0);
    allMultiEn = 1'b0;
  endtask

  task automatic testStationGroupBit();
    stationAddr = 48'h0000_0000_0A03;
    hashFilter  = ~(64'd1 << hashOf(48'h0000_0000_0A03));
    expectVerdict("R10 station with group bit", 48'h0000_0000_0A03, 1'b0);
    hashFilter = '0;
  endtask

  task automatic testPromisc();
    stationAddr = 48'h0000_0000_0A02;
    modeWord = 16'h7FFF;
    expectVerdict("R9 other mode bits", 48'h0000_0000_0C02, 1'b0);
    modeWord = 16'h8000;
    expectVerdict("R9 promiscuous", 48'h0000_0000_0C02, 1'b1);
    modeWord = 16'h0000;
  endtask

  task automatic testTiming();
    stationAddr = 48'h0000_0000_0A02;
    @(negedge clk); startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    for (int i = 0; i < 5; i++) begin
      byteValid = 1'b1; byteIn = stationAddr[8*i +: 8]; @(negedge clk);
    end
    check("R2 not valid after five bytes", decisionValid, 1'b0);
    byteIn = stationAddr[47:40]; @(negedge clk);
    check("R2 valid after sixth", decisionValid, 1'b1);
    check("R2 accept after sixth", acceptOut, 1'b1);
    // R3: extra bytes change nothing
    for (int i = 0; i < 4; i++) begin
      byteIn = 8'h77; @(negedge clk);
    end
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 held valid after extra bytes", decisionValid, 1'b1);
    check("R3 held accept after extra bytes", acceptOut, 1'b1);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    check("R2 start clears valid", decisionValid, 1'b0);
  endtask

  task automatic testMerged();
    stationAddr = 48'h0000_0000_0A02;
    sendAddr(48'h0000_0000_0A02, 1'b1);
    check("R4 merged start valid", decisionValid, 1'b1);
    check("R4 merged start accept", acceptOut, 1'b1);
    sendAddr(48'h0000_0000_0A04, 1'b1);
    check("R4 merged start reject", acceptOut, 1'b0);
    // R4: merged start while a decision is held drops valid next cycle
    @(negedge clk); startStrobe = 1'b1; byteValid = 1'b1; byteIn = 8'h02;
    @(negedge clk); startStrobe = 1'b0; byteValid = 1'b0;
    check("R4 merged start clears", decisionValid, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStation();
    testBroadcast();
    testHash();
    testStationGroupBit();
    testPromisc();
    testTiming();
    testMerged();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule